// File: doc/BRIEF.md
# Camera Control Bus Register Master

This block is the hardware master for the three-wire serial control bus used to program image sensors. A host hands it one register operation at a time. Each command carries a device ID byte, a register sub-address byte, a write-data byte and a read/write flag. The block then drives the bus clock line and the bidirectional data line until the operation is complete. The data line is handled as a tri-state pad with three signals: an output enable, an output value and an input sample.

A write is one bus transaction: a start condition, the ID byte, the sub-address byte, the data byte and a stop condition. A read is two transactions. The first is an address phase: start, ID byte, sub-address byte and stop. The second begins with a fresh start, then the ID byte with bit 0 forced to one, then one byte clocked in from the sensor, then a stop. The ninth clock of every byte is not an acknowledge check. On bytes the master sends, the line is released and its value is ignored. On the byte it receives, the master drives the line high as a no-acknowledge.

Bit timing comes from a divider count supplied on an input. Every half-period of the bus clock lasts exactly that many system clocks. The host sees `busy` while an operation runs. At the end it sees a one-cycle `done` pulse, and for reads the returned byte is valid on that same cycle.

Top module: `camreg_master`

## Requirements
- R1: After reset, and whenever no operation is running, the clock line is high, the data output enable is low (line released, resting high), `busy` is low and `done` is low.
- R2: A command on `cmd_valid` is taken only while `busy` is low, and `busy` reads high one cycle later. A `cmd_valid` pulse presented while `busy` is high has no effect: the running transaction is unchanged and no further transaction follows.
- R3: A write (`cmd_rd` = 0) produces exactly: start, `cmd_id`, `cmd_sub`, `cmd_wdata`, stop. Each byte is sent most significant bit first, and each bit is the data-line level at the rising edge of the clock line.
- R4: During the ninth clock of every byte the master sends, the data output enable is low.
- R5: A read (`cmd_rd` = 1) produces exactly: start, `cmd_id`, `cmd_sub`, stop, start, `cmd_id` with bit 0 set, one received byte, stop.
- R6: The received byte is sampled most significant bit first while the clock line is high, with the output enable low. It appears on `rd_data` in the cycle `done` is high.
- R7: During the ninth clock of the received byte, the master drives the data line high (output enable high, output value 1).
- R8: A start is a falling data line while the clock line stays high. A stop is a rising data line while the clock line stays high. After the final stop, the data line is released.
- R9: Every low interval of the clock line lasts exactly `half_period` system clocks (`half_period` of at least 2, held constant while `busy`).
- R10: `done` is high for exactly one cycle per operation, and `busy` is already low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_period | input | DIV_W | System clocks per bus-clock half-period (at least 2) |
| cmd_valid | input | 1 | Command request, taken when `busy` is low |
| cmd_rd | input | 1 | 1 = register read, 0 = register write |
| cmd_id | input | 8 | Device ID byte |
| cmd_sub | input | 8 | Register sub-address byte |
| cmd_wdata | input | 8 | Byte to write (ignored for reads) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte returned by the last read |
| bus_scl | output | 1 | Bus clock line |
| bus_sda_oe | output | 1 | Data line output enable |
| bus_sda_out | output | 1 | Data line output value |
| bus_sda_in | input | 1 | Data line level sampled from the pad |

## Verification
The hardest case to reach from the ports is the received byte. It only exists once the master has completed a full address transaction, issued a stop and a second start, and sent an ID with bit 0 set. The master samples its data only at the end of each clock-high half, after the sensor has placed the bit during the preceding low half.

The bench contains a bus-level slave model that decodes starts, stops and nine-bit groups from the line itself. It recognises the read frame from the low bit of the first byte after a start. It then drives a chosen byte on the falling clock edges until the eighth bit. The same decoded view is used to check the wait-while-busy case, where a second command is injected in the middle of a transaction.

// File: rtl/cbus_pkg.sv
package cbus_pkg;
  localparam int BYTE_W   = 8;
  localparam int STEP_W   = 3;
  localparam int HALVES_B = 2 * (BYTE_W + 1);
  localparam int HC_W     = $clog2(HALVES_B);

  typedef enum logic [2:0] {
    OP_IDLE, OP_START, OP_WBYTE, OP_RBYTE, OP_STOP
  } op_e;

  typedef enum logic [1:0] {
    SEL_ID, SEL_IDRD, SEL_SUB, SEL_DATA
  } sel_e;

  typedef struct packed {
    op_e  op;
    sel_e sel;
    logic last;
  } step_t;

  typedef struct packed {
    logic scl;
    logic oe;
    logic dout;
  } line_t;

  // Transaction script: the order of bus phases for each command kind.
  function automatic step_t script_step(input logic rd, input logic [STEP_W-1:0] idx);
    step_t s;
    s = '{op: OP_STOP, sel: SEL_ID, last: 1'b1};
    if (!rd) begin
      case (idx)
        3'd0: s = '{op: OP_START, sel: SEL_ID,   last: 1'b0};
        3'd1: s = '{op: OP_WBYTE, sel: SEL_ID,   last: 1'b0};
        3'd2: s = '{op: OP_WBYTE, sel: SEL_SUB,  last: 1'b0};
        3'd3: s = '{op: OP_WBYTE, sel: SEL_DATA, last: 1'b0};
        default: s = '{op: OP_STOP, sel: SEL_ID, last: 1'b1};
      endcase
    end else begin
      case (idx)
        3'd0: s = '{op: OP_START, sel: SEL_ID,   last: 1'b0};
        3'd1: s = '{op: OP_WBYTE, sel: SEL_ID,   last: 1'b0};
        3'd2: s = '{op: OP_WBYTE, sel: SEL_SUB,  last: 1'b0};
        3'd3: s = '{op: OP_STOP,  sel: SEL_ID,   last: 1'b0};
        3'd4: s = '{op: OP_START, sel: SEL_ID,   last: 1'b0};
        3'd5: s = '{op: OP_WBYTE, sel: SEL_IDRD, last: 1'b0};
        3'd6: s = '{op: OP_RBYTE, sel: SEL_ID,   last: 1'b0};
        default: s = '{op: OP_STOP, sel: SEL_ID, last: 1'b1};
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/cbus_tick_gen.sv
module cbus_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cbus_bit_engine.sv
module cbus_bit_engine
  import cbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  op_e               op,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              sda_in,
  output line_t             line,
  output logic              op_done,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int BIT_W = HC_W - 1;
  localparam int IDX_W = $clog2(BYTE_W);

  logic [HC_W-1:0]  hcnt;
  logic [HC_W-1:0]  last_half;
  logic [BIT_W-1:0] bitn;
  logic             in_data;
  logic [IDX_W-1:0] bidx;

  assign bitn    = hcnt[HC_W-1:1];
  assign in_data = bitn < BIT_W'(BYTE_W);
  assign bidx    = IDX_W'(BYTE_W - 1) - bitn[IDX_W-1:0];

  always_comb begin
    case (op)
      OP_START: last_half = '0;
      OP_STOP:  last_half = HC_W'(2);
      OP_WBYTE, OP_RBYTE: last_half = HC_W'(HALVES_B - 1);
      default:  last_half = '0;
    endcase
  end

  assign op_done = tick && (op != OP_IDLE) && (hcnt == last_half);

  // Half-period decode: odd half = clock high.
  always_comb begin
    line = '{scl: 1'b1, oe: 1'b0, dout: 1'b1};
    case (op)
      OP_START: line = '{scl: 1'b1, oe: 1'b1, dout: 1'b0};
      OP_STOP: begin
        line.scl  = (hcnt != '0);
        line.oe   = 1'b1;
        line.dout = (hcnt == HC_W'(2));
      end
      OP_WBYTE: begin
        line.scl  = hcnt[0];
        line.oe   = in_data;
        line.dout = in_data ? tx_byte[bidx] : 1'b1;
      end
      OP_RBYTE: begin
        line.scl  = hcnt[0];
        line.oe   = !in_data;
        line.dout = 1'b1;
      end
      default: line = '{scl: 1'b1, oe: 1'b0, dout: 1'b1};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt    <= '0;
      rx_byte <= '0;
    end else begin
      if (op == OP_IDLE)  hcnt <= '0;
      else if (tick)      hcnt <= op_done ? '0 : hcnt + 1'b1;
      if (tick && op == OP_RBYTE && hcnt[0] && in_data)
        rx_byte <= {rx_byte[BYTE_W-2:0], sda_in};
    end
  end
endmodule

// File: rtl/cbus_sequencer.sv
module cbus_sequencer
  import cbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_rd,
  input  logic [BYTE_W-1:0] cmd_id,
  input  logic [BYTE_W-1:0] cmd_sub,
  input  logic [BYTE_W-1:0] cmd_wdata,
  input  logic              op_done,
  input  logic [BYTE_W-1:0] rx_byte,
  output op_e               op,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rd_data
);
  logic [STEP_W-1:0] idx;
  logic              rd_q;
  logic [BYTE_W-1:0] id_q, sub_q, wd_q;
  step_t             step;

  assign step = script_step(rd_q, idx);
  assign op   = busy ? step.op : OP_IDLE;

  always_comb begin
    case (step.sel)
      SEL_ID:   tx_byte = id_q;
      SEL_IDRD: tx_byte = id_q | BYTE_W'(1);
      SEL_SUB:  tx_byte = sub_q;
      default:  tx_byte = wd_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      idx     <= '0;
      rd_q    <= 1'b0;
      id_q    <= '0;
      sub_q   <= '0;
      wd_q    <= '0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (cmd_valid) begin
          busy  <= 1'b1;
          idx   <= '0;
          rd_q  <= cmd_rd;
          id_q  <= cmd_id;
          sub_q <= cmd_sub;
          wd_q  <= cmd_wdata;
        end
      end else if (op_done) begin
        if (step.last) begin
          busy <= 1'b0;
          done <= 1'b1;
          if (rd_q) rd_data <= rx_byte;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/camreg_master.sv
module camreg_master
  import cbus_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] half_period,
  input  logic             cmd_valid,
  input  logic             cmd_rd,
  input  logic [7:0]       cmd_id,
  input  logic [7:0]       cmd_sub,
  input  logic [7:0]       cmd_wdata,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rd_data,
  output logic             bus_scl,
  output logic             bus_sda_oe,
  output logic             bus_sda_out,
  input  logic             bus_sda_in
);
  op_e               op;
  logic [BYTE_W-1:0] tx_byte;
  logic [BYTE_W-1:0] rx_byte;
  logic              tick;
  logic              op_done;
  line_t             line;

  cbus_sequencer seq_i (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_rd(cmd_rd),
    .cmd_id(cmd_id), .cmd_sub(cmd_sub), .cmd_wdata(cmd_wdata),
    .op_done(op_done), .rx_byte(rx_byte),
    .op(op), .tx_byte(tx_byte),
    .busy(busy), .done(done), .rd_data(rd_data)
  );

  cbus_tick_gen #(.DIV_W(DIV_W)) tick_i (
    .clk(clk), .rst(rst), .run(busy), .div(half_period), .tick(tick)
  );

  cbus_bit_engine eng_i (
    .clk(clk), .rst(rst), .tick(tick), .op(op), .tx_byte(tx_byte),
    .sda_in(bus_sda_in), .line(line), .op_done(op_done), .rx_byte(rx_byte)
  );

  // Pad-facing outputs are registered.
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_scl     <= 1'b1;
      bus_sda_oe  <= 1'b0;
      bus_sda_out <= 1'b1;
    end else begin
      bus_scl     <= line.scl;
      bus_sda_oe  <= line.oe;
      bus_sda_out <= line.dout;
    end
  end
endmodule

// File: rtl/cbus_master_chk.sv
module cbus_master_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [DIV_W-1:0] half_period,
  input logic             cmd_valid,
  input logic             busy,
  input logic             done,
  input logic             bus_scl,
  input logic             bus_sda_oe
);
  logic [DIV_W-1:0] low_run;

  always_ff @(posedge clk) begin
    if (rst || bus_scl) low_run <= '0;
    else                low_run <= low_run + 1'b1;
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_accept_when_free_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cmd_valid));

  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> (bus_scl && !bus_sda_oe));

  assert_low_len_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_scl) |-> (low_run == half_period));
endmodule

bind camreg_master cbus_master_chk #(.DIV_W(DIV_W)) chk_i (
  .clk(clk), .rst(rst), .half_period(half_period), .cmd_valid(cmd_valid),
  .busy(busy), .done(done), .bus_scl(bus_scl), .bus_sda_oe(bus_sda_oe)
);

// File: tb/camreg_master_tb_top.sv
module camreg_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 6;
  localparam int TOK_START  = 256;
  localparam int TOK_STOP   = 257;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [DIV_W-1:0] half_period = DIV_W'(3);
  logic             cmd_valid = 1'b0;
  logic             cmd_rd = 1'b0;
  logic [7:0]       cmd_id = '0, cmd_sub = '0, cmd_wdata = '0;
  logic             busy, done;
  logic [7:0]       rd_data;
  logic             bus_scl, bus_sda_oe, bus_sda_out, bus_sda_in;
  logic             slv_en = 1'b0, slv_bit = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign bus_sda_in = bus_sda_oe ? bus_sda_out : (slv_en ? slv_bit : 1'b1);

  camreg_master #(.DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst(rst), .half_period(half_period),
    .cmd_valid(cmd_valid), .cmd_rd(cmd_rd), .cmd_id(cmd_id),
    .cmd_sub(cmd_sub), .cmd_wdata(cmd_wdata),
    .busy(busy), .done(done), .rd_data(rd_data),
    .bus_scl(bus_scl), .bus_sda_oe(bus_sda_oe), .bus_sda_out(bus_sda_out),
    .bus_sda_in(bus_sda_in)
  );

  int n_tests = 0, n_fail = 0;

  // Bus monitor and slave model state
  int         tok [0:15];
  logic       nine[0:15];
  logic       oe9 [0:15];
  int         ntok = 0;
  logic [7:0] slave_val = 8'h00;
  logic       p_scl, p_sda, cur_oe9, rd_frame;
  logic [8:0] sh;
  int         bitcnt, bif, lowrun, lowbad;

  task automatic push(input int v, input logic n, input logic o);
    if (ntok < 16) begin
      tok[ntok] = v; nine[ntok] = n; oe9[ntok] = o;
    end
    ntok++;
  endtask

  always @(negedge clk) begin
    if (rst) begin
      p_scl = 1'b1; p_sda = 1'b1; bitcnt = 0; bif = 0; lowrun = 0;
      lowbad = 0; rd_frame = 1'b0; sh = '0; cur_oe9 = 1'b0; slv_en = 1'b0;
    end else begin
      if (bus_scl && p_scl && p_sda && !bus_sda_in) begin
        push(TOK_START, 1'b0, 1'b0);
        bitcnt = 0; bif = 0; rd_frame = 1'b0;
      end else if (bus_scl && p_scl && !p_sda && bus_sda_in) begin
        push(TOK_STOP, 1'b0, 1'b0);
        bitcnt = 0; slv_en = 1'b0;
      end
      if (bus_scl && !p_scl) begin
        if (lowrun != int'(half_period)) lowbad++;
        sh = {sh[7:0], bus_sda_in};
        if (bitcnt == 8) cur_oe9 = bus_sda_oe;
        bitcnt++;
        if (bitcnt == 9) begin
          push(int'(sh[8:1]), sh[0], cur_oe9);
          if (bif == 0) rd_frame = sh[1];
          bif++;
          bitcnt = 0;
        end
      end
      if (!bus_scl && p_scl) begin
        if (rd_frame && bif == 1 && bitcnt < 8) begin
          slv_en = 1'b1; slv_bit = slave_val[7 - bitcnt];
        end else begin
          slv_en = 1'b0;
        end
      end
      lowrun = bus_scl ? 0 : lowrun + 1;
      p_scl = bus_scl;
      p_sda = bus_sda_in;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Issue one command; optionally inject a second command while busy.
  task automatic run_cmd(input logic rd, input logic [7:0] id, input logic [7:0] sub,
                         input logic [7:0] wd, input bit inject);
    int exp_t[0:7];
    int nexp, bad, cyc, ntok_end;
    logic [7:0] got;
    @(negedge clk);
    ntok = 0; lowbad = 0;
    cmd_rd = rd; cmd_id = id; cmd_sub = sub; cmd_wdata = wd; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy === 1'b1, "R2", "busy after accept", int'(busy), 1);
    cyc = 0;
    while (busy === 1'b1 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (inject && cyc == 40) begin
        cmd_rd = ~rd; cmd_id = 8'h11; cmd_sub = 8'h22; cmd_wdata = 8'h33;
        cmd_valid = 1'b1;
      end else begin
        cmd_valid = 1'b0;
      end
    end
    cmd_valid = 1'b0;
    check(cyc < 20000, "R10", "completion timeout", cyc, 0);
    check(done === 1'b1, "R10", "done with busy low", int'(done), 1);
    got = rd_data;
    @(negedge clk);
    check(done === 1'b0, "R10", "done one cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    check(bus_scl === 1'b1 && bus_sda_oe === 1'b0, "R8", "line released after stop",
          int'({bus_scl, bus_sda_oe}), 2);
    check(lowbad == 0, "R9", "clock low interval length", lowbad, 0);
    if (!rd) begin
      exp_t[0] = TOK_START; exp_t[1] = id; exp_t[2] = sub; exp_t[3] = wd;
      exp_t[4] = TOK_STOP; nexp = 5;
    end else begin
      exp_t[0] = TOK_START; exp_t[1] = id; exp_t[2] = sub; exp_t[3] = TOK_STOP;
      exp_t[4] = TOK_START; exp_t[5] = int'(id | 8'h01); exp_t[6] = slave_val;
      exp_t[7] = TOK_STOP; nexp = 8;
    end
    bad = 0;
    for (int i = 0; i < nexp; i++)
      if (i >= ntok || tok[i] != exp_t[i]) bad++;
    if (!rd) begin
      check(ntok == nexp && bad == 0, "R3", "write sequence",
            (ntok > 3) ? tok[3] : -1, int'(wd));
      check(!oe9[1] && !oe9[2] && !oe9[3], "R4", "write ninth bit released",
            int'({oe9[1], oe9[2], oe9[3]}), 0);
    end else begin
      check(ntok == nexp && bad == 0, "R5", "read sequence",
            (ntok > 5) ? tok[5] : -1, int'(id | 8'h01));
      check(!oe9[1] && !oe9[2] && !oe9[5], "R4", "address bytes ninth released",
            int'({oe9[1], oe9[2], oe9[5]}), 0);
      check(got == slave_val, "R6", "read data on done", int'(got), int'(slave_val));
      check(nine[6] === 1'b1 && oe9[6] === 1'b1, "R7", "read ninth bit driven high",
            int'({nine[6], oe9[6]}), 3);
    end
    if (inject) begin
      ntok_end = ntok;
      repeat (200) @(negedge clk);
      check(ntok == ntok_end && busy === 1'b0, "R2", "command while busy ignored",
            ntok, ntok_end);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int divs[3] = '{2, 3, 7};
    logic [7:0] pat;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(bus_scl === 1'b1 && bus_sda_oe === 1'b0 && busy === 1'b0 && done === 1'b0,
          "R1", "reset idle state", int'({bus_scl, bus_sda_oe, busy, done}), 8);
    foreach (divs[d]) begin
      half_period = DIV_W'(divs[d]);
      for (int k = 0; k < 10; k++) begin
        pat = (k == 8) ? 8'h00 : (k == 9) ? 8'hFF : (8'h01 << k);
        run_cmd(1'b0, 8'h60 + 8'(2 * k), ~pat, pat, 1'b0);
        slave_val = pat ^ 8'(k * 8'h35);
        run_cmd(1'b1, 8'h42 + 8'(4 * k), pat, 8'h00, 1'b0);
      end
    end
    half_period = DIV_W'(3);
    run_cmd(1'b0, 8'h5A, 8'h3C, 8'hC3, 1'b1);
    slave_val = 8'h96;
    run_cmd(1'b1, 8'h31, 8'h0B, 8'h00, 1'b1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule